// File: doc/BRIEF.md
# GPIO Port Controller with Configuration Lock

This block controls a port of sixteen general-purpose pins through a simple register bus. For each pin, software selects a direction mode, an output driver type, a drive strength, a pull resistor setting and a 4-bit alternate-function number. The block drives these settings on output ports towards the pad ring and the peripheral multiplexer. It keeps an output data word that software can write whole. It can also change that word bit by bit through write-only set and clear registers, so no read-modify-write is needed. Pad inputs are brought in through a two-flop synchronizer and can be read back.

A lock register protects the configuration of selected pins. The protection takes effect only after a three-write key sequence. From then on, the configuration fields of the locked pins ignore writes until the next reset.

The bus is single-cycle. A write is taken on the rising clock edge while `bus_we` is high. Read data is a combinational function of `bus_addr`. The external reset is asynchronous and active-low. Inside the block it is released synchronously, two clock edges after `rst_n` rises.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset every configuration field is 0 (all pins inputs, no pull, push-pull, alternate function 0), the output word is 0, and the lock register reads 0.
- R2: Offset 0 holds the mode fields, 2 bits per pin with pin p at bits 2p+1:2p. The codes are 00 input, 01 output, 10 alternate function and 11 analog. The register reads back as written and is driven on `pin_mode`.
- R3: Offset 1 holds the driver type (bit p = 1 means open-drain). Offset 2 holds the 2-bit speed fields and offset 3 the 2-bit pull fields (00 none, 01 up, 10 down), both at bits 2p+1:2p. Each of these is driven on its own port.
- R4: The alternate-function number of pins 0 to 7 is at offset 4 and that of pins 8 to 15 at offset 5, in bits 4*(p mod 8)+3 : 4*(p mod 8). `pin_af` carries pin p at bits 4p+3:4p.
- R5: Offset 7 is the output word, readable and writable. A write to offset 8 sets the pins in bits 15:0 and clears the pins in bits 31:16. Set wins when both name the same pin, other pins keep their value, and offset 8 reads 0.
- R6: A write to offset 9 clears the pins named in bits 15:0 and leaves the others unchanged. Offset 9 reads 0.
- R7: Offset 6 reads the pad inputs through a two-flop synchronizer. A pad change is visible after the second rising edge. Pins in analog mode read 0, and writes to offset 6 have no effect.
- R8: Offset 10 is the lock register: key at bit 16, pin mask at bits 15:0. Three writes of (key 1, mask m), (key 0, m), (key 1, m) make it read key 1 with mask m, and it keeps that value until reset.
- R9: Once locked, writes to offsets 0 to 5 leave the fields of locked pins unchanged, while the fields of unlocked pins and the output word stay writable.
- R10: A second write with a different mask, or any write to another offset in the middle of the sequence, aborts it. No pins are locked, the key stays 0, and a later full sequence starts from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pin_mode | output | 32 | Mode field per pin |
| pin_odrain | output | 16 | Open-drain select per pin |
| pin_speed | output | 32 | Speed field per pin |
| pin_pull | output | 32 | Pull field per pin |
| pin_af | output | 64 | Alternate-function number per pin |
| pin_out | output | 16 | Output data word |

## Verification
Register and output-word writes land on the clock edge that takes them. The bench therefore drives every write at a falling edge and samples the read data and pin ports at the next falling edge, one cycle later. Pad input is due two rising edges after a change. The bench samples once after the first edge, expecting the old value, and again after the second edge, expecting the new one. Lock effects are checked with a write and a read-back right after the third key write, so a lock that arrives late or not at all shows up as a mismatch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_OUT = 2'b01,
    MODE_ALT = 2'b10,
    MODE_ANA = 2'b11
  } pin_mode_e;

  localparam int OFS_MODE  = 0;
  localparam int OFS_OTYPE = 1;
  localparam int OFS_SPEED = 2;
  localparam int OFS_PULL  = 3;
  localparam int OFS_AFLO  = 4;
  localparam int OFS_AFHI  = 5;
  localparam int OFS_IN    = 6;
  localparam int OFS_OUT   = 7;
  localparam int OFS_SETCL = 8;
  localparam int OFS_CLR   = 9;
  localparam int OFS_LOCK  = 10;
endpackage

// File: rtl/gpio_cfg_field.sv
module gpio_cfg_field #(
  parameter int PINS = 16,
  parameter int FW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PINS-1:0]    wr_en,
  input  logic [PINS*FW-1:0] wdata,
  input  logic [PINS-1:0]    lock,
  output logic [PINS*FW-1:0] q
);
  logic [PINS*FW-1:0] d;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    always_comb begin
      d[p*FW +: FW] = q[p*FW +: FW];
      if (wr_en[p] && !lock[p]) d[p*FW +: FW] = wdata[p*FW +: FW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[p*FW +: FW] <= '0;
      else        q[p*FW +: FW] <= d[p*FW +: FW];
    end

    assert_locked_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock[p] |=> $stable(q[p*FW +: FW]));
  end
endmodule

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock_wr,
  input  logic            other_wr,
  input  logic            key_in,
  input  logic [PINS-1:0] mask_in,
  output logic            key_q,
  output logic [PINS-1:0] mask_q
);
  typedef enum logic [1:0] {ST_IDLE, ST_ARM1, ST_ARM2} seq_e;
  seq_e            st_q, st_d;
  logic [PINS-1:0] cand_q, cand_d, mask_d;
  logic            key_d;

  always_comb begin
    st_d   = st_q;
    cand_d = cand_q;
    key_d  = key_q;
    mask_d = mask_q;
    if (!key_q) begin
      if (lock_wr) begin
        unique case (st_q)
          ST_IDLE: if (key_in) begin st_d = ST_ARM1; cand_d = mask_in; end
          ST_ARM1: st_d = (!key_in && mask_in == cand_q) ? ST_ARM2 : ST_IDLE;
          ST_ARM2: begin
            st_d = ST_IDLE;
            if (key_in && mask_in == cand_q) begin
              key_d  = 1'b1;
              mask_d = cand_q;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end else if (other_wr) begin
        st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cand_q <= '0;
      key_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      cand_q <= cand_d;
      key_q  <= key_d;
      mask_q <= mask_d;
    end
  end

  assert_key_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_q |=> key_q);
  assert_mask_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_q |=> $stable(mask_q));
  assert_abort_no_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_q && other_wr) |=> !key_q);
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word,
  input  logic              wr_setcl,
  input  logic              wr_clr,
  input  logic [2*PINS-1:0] wdata,
  output logic [PINS-1:0]   q
);
  logic [PINS-1:0] d;
  logic [PINS-1:0] set_m, clr_m;

  assign set_m = wdata[PINS-1:0];
  assign clr_m = wdata[2*PINS-1:PINS];

  always_comb begin
    d = q;
    if (wr_word)  d = set_m;
    if (wr_clr)   d = q & ~set_m;
    if (wr_setcl) d = (q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setcl |=> ((q & $past(set_m)) == $past(set_m)));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((q & $past(set_m)) == '0));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad,
  output logic [PINS-1:0] q
);
  logic [PINS-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= pad;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [2*PINS-1:0] pin_mode,
  output logic [PINS-1:0]   pin_odrain,
  output logic [2*PINS-1:0] pin_speed,
  output logic [2*PINS-1:0] pin_pull,
  output logic [4*PINS-1:0] pin_af,
  output logic [PINS-1:0]   pin_out
);
  localparam int AF_W    = 4 * PINS;
  localparam int HALF    = PINS / 2;
  localparam int HALF_AF = AF_W / 2;

  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic            we_mode, we_otype, we_speed, we_pull, we_aflo, we_afhi;
  logic [PINS-1:0] af_wen;
  logic [PINS-1:0] lock_mask;
  logic            lock_key;
  logic [PINS-1:0] in_sync, in_vis;

  assign we_mode  = bus_we && hit(bus_addr, OFS_MODE);
  assign we_otype = bus_we && hit(bus_addr, OFS_OTYPE);
  assign we_speed = bus_we && hit(bus_addr, OFS_SPEED);
  assign we_pull  = bus_we && hit(bus_addr, OFS_PULL);
  assign we_aflo  = bus_we && hit(bus_addr, OFS_AFLO);
  assign we_afhi  = bus_we && hit(bus_addr, OFS_AFHI);

  for (genvar p = 0; p < PINS; p++) begin : g_af_wen
    if (p < HALF) begin : g_lo
      assign af_wen[p] = we_aflo;
    end else begin : g_hi
      assign af_wen[p] = we_afhi;
    end
  end

  gpio_cfg_field #(.PINS(PINS), .FW(2)) u_mode (
    .clk(clk), .rst_n(rst_sync_n), .wr_en({PINS{we_mode}}),
    .wdata(bus_wdata[2*PINS-1:0]), .lock(lock_mask), .q(pin_mode));

  gpio_cfg_field #(.PINS(PINS), .FW(1)) u_otype (
    .clk(clk), .rst_n(rst_sync_n), .wr_en({PINS{we_otype}}),
    .wdata(bus_wdata[PINS-1:0]), .lock(lock_mask), .q(pin_odrain));

  gpio_cfg_field #(.PINS(PINS), .FW(2)) u_speed (
    .clk(clk), .rst_n(rst_sync_n), .wr_en({PINS{we_speed}}),
    .wdata(bus_wdata[2*PINS-1:0]), .lock(lock_mask), .q(pin_speed));

  gpio_cfg_field #(.PINS(PINS), .FW(2)) u_pull (
    .clk(clk), .rst_n(rst_sync_n), .wr_en({PINS{we_pull}}),
    .wdata(bus_wdata[2*PINS-1:0]), .lock(lock_mask), .q(pin_pull));

  gpio_cfg_field #(.PINS(PINS), .FW(4)) u_af (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(af_wen),
    .wdata({2{bus_wdata[HALF_AF-1:0]}}), .lock(lock_mask), .q(pin_af));

  gpio_lock_seq #(.PINS(PINS)) u_lock (
    .clk(clk), .rst_n(rst_sync_n),
    .lock_wr(bus_we && hit(bus_addr, OFS_LOCK)),
    .other_wr(bus_we && !hit(bus_addr, OFS_LOCK)),
    .key_in(bus_wdata[PINS]), .mask_in(bus_wdata[PINS-1:0]),
    .key_q(lock_key), .mask_q(lock_mask));

  gpio_out_reg #(.PINS(PINS)) u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_word(bus_we && hit(bus_addr, OFS_OUT)),
    .wr_setcl(bus_we && hit(bus_addr, OFS_SETCL)),
    .wr_clr(bus_we && hit(bus_addr, OFS_CLR)),
    .wdata(bus_wdata[2*PINS-1:0]), .q(pin_out));

  gpio_in_sync #(.PINS(PINS)) u_in (
    .clk(clk), .rst_n(rst_sync_n), .pad(pad_in), .q(in_sync));

  for (genvar p = 0; p < PINS; p++) begin : g_in_mask
    assign in_vis[p] = in_sync[p] && (pin_mode[2*p +: 2] != MODE_ANA);
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFS_MODE))  bus_rdata = DATA_W'(pin_mode);
    if (hit(bus_addr, OFS_OTYPE)) bus_rdata = DATA_W'(pin_odrain);
    if (hit(bus_addr, OFS_SPEED)) bus_rdata = DATA_W'(pin_speed);
    if (hit(bus_addr, OFS_PULL))  bus_rdata = DATA_W'(pin_pull);
    if (hit(bus_addr, OFS_AFLO))  bus_rdata = DATA_W'(pin_af[HALF_AF-1:0]);
    if (hit(bus_addr, OFS_AFHI))  bus_rdata = DATA_W'(pin_af[AF_W-1:HALF_AF]);
    if (hit(bus_addr, OFS_IN))    bus_rdata = DATA_W'(in_vis);
    if (hit(bus_addr, OFS_OUT))   bus_rdata = DATA_W'(pin_out);
    if (hit(bus_addr, OFS_LOCK))  bus_rdata = DATA_W'({lock_key, lock_mask});
  end
endmodule

// File: tb/gpio_port_ctl_tb.sv
module gpio_port_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] pad_in;
  logic [31:0] pin_mode, pin_speed, pin_pull;
  logic [15:0] pin_odrain, pin_out;
  logic [63:0] pin_af;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_port_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pin_mode(pin_mode), .pin_odrain(pin_odrain), .pin_speed(pin_speed),
    .pin_pull(pin_pull), .pin_af(pin_af), .pin_out(pin_out));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic lock_seq(input logic [15:0] m);
    wr(4'd10, {15'h0, 1'b1, m});
    wr(4'd10, {15'h0, 1'b0, m});
    wr(4'd10, {15'h0, 1'b1, m});
  endtask

  task automatic t_reset();
    rd_check("R1 mode reset", 4'd0, 32'h0);
    rd_check("R1 pull reset", 4'd3, 32'h0);
    rd_check("R1 af lo reset", 4'd4, 32'h0);
    rd_check("R1 af hi reset", 4'd5, 32'h0);
    rd_check("R1 lock reset", 4'd10, 32'h0);
    check("R1 ports reset", {pin_af[31:0], pin_mode}, 64'h0);
    check("R1 out reset", {48'h0, pin_out}, 64'h0);
  endtask

  task automatic t_modes();
    wr(4'd0, 32'hB1E4_27D8);
    rd_check("R2 mode readback", 4'd0, 32'hB1E4_27D8);
    check("R2 pin_mode port", {32'h0, pin_mode}, 64'hB1E4_27D8);
  endtask

  task automatic t_drive();
    wr(4'd1, 32'h0000_A5C3);
    wr(4'd2, 32'h1234_5678);
    wr(4'd3, 32'h0000_9999);
    check("R3 odrain port", {48'h0, pin_odrain}, 64'hA5C3);
    check("R3 speed port", {32'h0, pin_speed}, 64'h1234_5678);
    check("R3 pull port", {32'h0, pin_pull}, 64'h9999);
    rd_check("R3 otype readback", 4'd1, 32'h0000_A5C3);
  endtask

  task automatic t_af();
    wr(4'd4, 32'h7654_3210);
    wr(4'd5, 32'hFEDC_BA98);
    check("R4 pin_af port", pin_af, 64'hFEDC_BA98_7654_3210);
    check("R4 pin 9 field", {60'h0, pin_af[39:36]}, 64'h9);
    rd_check("R4 af hi readback", 4'd5, 32'hFEDC_BA98);
  endtask

  task automatic t_out();
    wr(4'd7, 32'h0000_00FF);
    rd_check("R5 out word", 4'd7, 32'h0000_00FF);
    wr(4'd8, 32'h0F00_F000);
    check("R5 set/clear masks", {48'h0, pin_out}, 64'hF0FF);
    wr(4'd8, 32'h0003_0001);
    check("R5 set wins over clear", {48'h0, pin_out}, 64'hF0FD);
    rd_check("R5 set reg reads 0", 4'd8, 32'h0);
    wr(4'd9, 32'h0000_00F0);
    check("R6 clear reg", {48'h0, pin_out}, 64'hF00D);
    rd_check("R6 clear reg reads 0", 4'd9, 32'h0);
  endtask

  task automatic t_input();
    wr(4'd0, 32'h0);
    @(negedge clk);
    pad_in = 16'h1234;
    @(negedge clk);
    rd_check("R7 not yet after one edge", 4'd6, 32'h0);
    @(negedge clk);
    rd_check("R7 visible after two edges", 4'd6, 32'h1234);
    wr(4'd0, 32'h0000_0030);
    rd_check("R7 analog pin reads 0", 4'd6, 32'h1230);
    wr(4'd6, 32'hFFFF_FFFF);
    rd_check("R7 input write ignored", 4'd6, 32'h1230);
  endtask

  task automatic t_abort();
    wr(4'd10, 32'h0001_00F0);
    wr(4'd10, 32'h0000_00F1);
    wr(4'd10, 32'h0001_00F1);
    rd_check("R10 mask change aborts", 4'd10, 32'h0);
    wr(4'd10, 32'h0001_00F0);
    wr(4'd1, 32'h0);
    wr(4'd10, 32'h0000_00F0);
    wr(4'd10, 32'h0001_00F0);
    rd_check("R10 other write aborts", 4'd10, 32'h0);
    wr(4'd0, 32'h0000_5500);
    rd_check("R10 pins stay unlocked", 4'd0, 32'h0000_5500);
  endtask

  task automatic t_lock();
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h0);
    wr(4'd3, 32'h0000_0005);
    lock_seq(16'h000F);
    rd_check("R8 key and mask", 4'd10, 32'h0001_000F);
    wr(4'd0, 32'hFFFF_FFFF);
    rd_check("R9 mode locked pins", 4'd0, 32'hFFFF_FF00);
    wr(4'd1, 32'h0000_FFFF);
    check("R9 otype locked pins", {48'h0, pin_odrain}, 64'hFFF0);
    wr(4'd3, 32'hFFFF_FFFF);
    rd_check("R9 pull locked pins", 4'd3, 32'hFFFF_FF05);
    wr(4'd4, 32'hFFFF_FFFF);
    rd_check("R9 af lo locked pins", 4'd4, 32'hFFFF_3210);
    wr(4'd7, 32'h0000_0003);
    check("R9 out word unaffected", {48'h0, pin_out}, 64'h3);
    lock_seq(16'hFF00);
    rd_check("R8 lock reg frozen", 4'd10, 32'h0001_000F);
  endtask

  task automatic t_reset_again();
    do_reset();
    rd_check("R8 lock cleared by reset", 4'd10, 32'h0);
    rd_check("R1 mode after second reset", 4'd0, 32'h0);
  endtask

  initial begin
    pad_in = '0;
    do_reset();
    t_reset();
    t_modes();
    t_drive();
    t_af();
    t_out();
    t_input();
    t_abort();
    t_lock();
    t_reset_again();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule